// File: doc/BRIEF.md
# PLL Rate-Change Clock Parking Sequencer

This block steers a processor clock away from a PLL while the PLL is being reprogrammed, then steers it back. It drives two mux selects. The output select picks between the crystal clock and the divider path. The source select picks what feeds the divider path, either the crystal or the PLL.

Before a frequency change, software or a power controller pulses `pre_req`. The block parks the output on the crystal and waits a settle time measured in microsecond ticks. It then points the source mux at the PLL and acknowledges. After the PLL has been reprogrammed, a pulse on `post_req` returns the output to the divider path. The block waits the same settle time and acknowledges again. Requests that arrive at the wrong moment are dropped and reported on one-cycle error pulses.

Top module: `clk_park_seq`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `out_sel` is 0 (crystal), `src_sel` is 0, and `busy`, `pre_ack`, `post_ack`, `err_busy` and `err_order` are all 0.
- R2: A `pre_req` sampled while idle is accepted. From the next cycle, `out_sel` is 0 and `busy` is 1, and `src_sel` keeps its value.
- R3: After a `pre_req` is accepted, `us_tick` pulses are counted on the edges after the accepting edge, and only while busy. On the edge that samples the SETTLE_US-th counted tick, the phase ends. From the next cycle, `src_sel` is 1 (PLL), `busy` is 0 and `pre_ack` is 1.
- R4: A `post_req` sampled while idle is accepted only when a pre phase has completed and no post phase has completed since. From the next cycle, `out_sel` is 1 (divider path) and `busy` is 1.
- R5: A post phase ends after SETTLE_US counted ticks, with the same counting rule as R3. From the next cycle, `busy` is 0 and `post_ack` is 1. `src_sel` is not changed by a post phase.
- R6: A `pre_req` or `post_req` sampled while `busy` is 1 is ignored. In the next cycle, `err_busy` is 1. The selects are unchanged, and the running settle count is unaffected.
- R7: A `post_req` sampled while idle without a completed, unconsumed pre phase is rejected. In the next cycle, `err_order` is 1, and `busy` and both selects are unchanged.
- R8: When `pre_req` and `post_req` are sampled together while idle, the pre request is accepted as in R2, and the post request is flagged on `err_busy` in the next cycle.
- R9: `pre_ack` and `post_ack` are single-cycle pulses and are never 1 in the same cycle.
- R10: `us_tick` pulses sampled while idle have no effect on the outputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| us_tick | input | 1 | One-cycle pulse per elapsed microsecond |
| pre_req | input | 1 | Pulse: PLL is about to change, park the clock |
| post_req | input | 1 | Pulse: PLL change finished, restore the clock |
| out_sel | output | 1 | Output mux select: 0 crystal, 1 divider path |
| src_sel | output | 1 | Source mux select: 0 crystal, 1 PLL |
| busy | output | 1 | High while a pre or post phase is running |
| pre_ack | output | 1 | One-cycle pulse when a pre phase completes |
| post_ack | output | 1 | One-cycle pulse when a post phase completes |
| err_busy | output | 1 | One-cycle pulse: request dropped because busy or colliding |
| err_order | output | 1 | One-cycle pulse: post request rejected as out of order |

## Verification
Every output is registered. A request sampled on one edge shows its effect on `out_sel`, `busy` and the error pulses from that edge onward. The edge that samples the last settle tick sets the acks and `src_sel`. The bench drives its inputs on falling edges and steps its reference model on each rising edge using those inputs. It then compares every output with the model on the following falling edge, so each result is checked in the exact cycle it is due. The tick rate is varied across phases, and directed checks at the same falling-edge points cover reset, collisions and ordering.

// File: rtl/clk_park_pkg.sv
package clk_park_pkg;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_PRE  = 2'd1,
    PH_POST = 2'd2
  } phase_e;

  // True when the tick being counted now is the final one of the window.
  function automatic logic is_last_tick(input int unsigned count,
                                        input int unsigned limit);
    return (count + 1) >= limit;
  endfunction

endpackage

// File: rtl/park_settle_timer.sv
module park_settle_timer #(
  parameter int unsigned LIMIT = 100
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic tick,
  output logic expired
);
  import clk_park_pkg::*;

  localparam int unsigned CW = $clog2(LIMIT + 1);

  logic          running;
  logic [CW-1:0] cnt;
  logic          last_tick;

  assign last_tick = is_last_tick(32'(cnt), LIMIT);
  assign expired   = running && tick && last_tick;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      running <= 1'b0;
      cnt     <= '0;
    end else if (start) begin
      running <= 1'b1;
      cnt     <= '0;
    end else if (running && tick) begin
      if (last_tick) begin
        running <= 1'b0;
        cnt     <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  // R3: the count never passes the end of the window
  assert_cnt_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    32'(cnt) < LIMIT);

  // R10: the count does not move while no window is open
  assert_idle_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!running && !start) |=> (cnt == '0));

endmodule

// File: rtl/park_req_arbiter.sv
module park_req_arbiter (
  input  logic idle,
  input  logic armed,
  input  logic pre_req,
  input  logic post_req,
  output logic take_pre,
  output logic take_post,
  output logic flag_busy,
  output logic flag_order
);
  always_comb begin
    take_pre   = idle && pre_req;
    take_post  = idle && post_req && !pre_req && armed;
    flag_order = idle && post_req && !pre_req && !armed;
    flag_busy  = (!idle && (pre_req || post_req)) ||
                 (idle && pre_req && post_req);
  end
endmodule

// File: rtl/clk_park_seq.sv
module clk_park_seq #(
  parameter int unsigned SETTLE_US = 100
) (
  input  logic clk,
  input  logic rst_n,
  input  logic us_tick,
  input  logic pre_req,
  input  logic post_req,
  output logic out_sel,
  output logic src_sel,
  output logic busy,
  output logic pre_ack,
  output logic post_ack,
  output logic err_busy,
  output logic err_order
);
  import clk_park_pkg::*;

  phase_e phase;
  logic   armed;
  logic   idle;
  logic   take_pre, take_post, flag_busy, flag_order;
  logic   seq_start, seq_finish;

  assign idle      = (phase == PH_IDLE);
  assign busy      = !idle;
  assign seq_start = take_pre || take_post;

  park_req_arbiter u_arb (
    .idle       (idle),
    .armed      (armed),
    .pre_req    (pre_req),
    .post_req   (post_req),
    .take_pre   (take_pre),
    .take_post  (take_post),
    .flag_busy  (flag_busy),
    .flag_order (flag_order)
  );

  park_settle_timer #(.LIMIT(SETTLE_US)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (seq_start),
    .tick    (us_tick),
    .expired (seq_finish)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase     <= PH_IDLE;
      armed     <= 1'b0;
      out_sel   <= 1'b0;
      src_sel   <= 1'b0;
      pre_ack   <= 1'b0;
      post_ack  <= 1'b0;
      err_busy  <= 1'b0;
      err_order <= 1'b0;
    end else begin
      pre_ack   <= 1'b0;
      post_ack  <= 1'b0;
      err_busy  <= flag_busy;
      err_order <= flag_order;
      if (take_pre) begin
        phase   <= PH_PRE;
        out_sel <= 1'b0;
        armed   <= 1'b0;
      end else if (take_post) begin
        phase   <= PH_POST;
        out_sel <= 1'b1;
      end else if (seq_finish) begin
        phase <= PH_IDLE;
        if (phase == PH_PRE) begin
          src_sel <= 1'b1;
          armed   <= 1'b1;
          pre_ack <= 1'b1;
        end else begin
          armed    <= 1'b0;
          post_ack <= 1'b1;
        end
      end
    end
  end

  assert_park_first_R2: assert property (@(posedge clk) disable iff (!rst_n)
    take_pre |=> (!out_sel && busy));

  assert_src_on_ack_R3: assert property (@(posedge clk) disable iff (!rst_n)
    pre_ack |-> (src_sel && !busy));

  assert_return_path_R4: assert property (@(posedge clk) disable iff (!rst_n)
    take_post |=> (out_sel && busy));

  assert_src_kept_R5: assert property (@(posedge clk) disable iff (!rst_n)
    post_ack |-> $stable(src_sel));

  assert_busy_ignore_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && (pre_req || post_req)) |=> (err_busy && $stable(out_sel)));

  assert_order_reject_R7: assert property (@(posedge clk) disable iff (!rst_n)
    err_order |-> (!busy && $stable(out_sel) && $stable(src_sel)));

  assert_collide_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && pre_req && post_req) |=> (err_busy && busy && !out_sel));

  assert_ack_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (pre_ack || post_ack) |=> (!pre_ack && !post_ack));

  assert_ack_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(pre_ack && post_ack));

endmodule

// File: tb/clk_park_seq_tb_top.sv
module clk_park_seq_tb_top;
  localparam int unsigned SETTLE = 100;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic us_tick = 1'b0;
  logic pre_req = 1'b0;
  logic post_req = 1'b0;
  logic out_sel, src_sel, busy, pre_ack, post_ack, err_busy, err_order;

  always #2.5 clk = ~clk;

  clk_park_seq #(.SETTLE_US(SETTLE)) dut_i (
    .clk(clk), .rst_n(rst_n), .us_tick(us_tick), .pre_req(pre_req),
    .post_req(post_req), .out_sel(out_sel), .src_sel(src_sel), .busy(busy),
    .pre_ack(pre_ack), .post_ack(post_ack), .err_busy(err_busy),
    .err_order(err_order)
  );

  int compared = 0;
  int mismatched = 0;
  int cycles = 0;
  int tick_div = 3;
  int tick_cnt = 0;
  bit done = 0;

  // reference model state
  int  m_phase = 0;  // 0 idle, 1 parking, 2 restoring
  int  m_left = 0;
  bit  m_ready = 0;
  bit  m_out = 0, m_src = 0, m_pack = 0, m_qack = 0, m_eb = 0, m_eo = 0;
  bit  prev_pack = 0, prev_qack = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // tick source, changed on falling edges
  always @(negedge clk) begin
    tick_cnt = tick_cnt + 1;
    us_tick <= (tick_cnt % tick_div) == 0;
  end

  // behavioural model stepped on each rising edge
  always @(posedge clk) begin
    cycles++;
    if (!rst_n) begin
      m_phase = 0; m_left = 0; m_ready = 0;
      m_out = 0; m_src = 0; m_pack = 0; m_qack = 0; m_eb = 0; m_eo = 0;
    end else begin
      m_pack = 0; m_qack = 0; m_eb = 0; m_eo = 0;
      if (m_phase == 0) begin
        if (pre_req) begin
          m_phase = 1; m_left = SETTLE; m_out = 0; m_ready = 0;
          if (post_req) m_eb = 1;
        end else if (post_req) begin
          if (m_ready) begin
            m_phase = 2; m_left = SETTLE; m_out = 1;
          end else m_eo = 1;
        end
      end else begin
        if (pre_req || post_req) m_eb = 1;
        if (us_tick) begin
          m_left--;
          if (m_left == 0) begin
            if (m_phase == 1) begin m_src = 1; m_ready = 1; m_pack = 1; end
            else begin m_ready = 0; m_qack = 1; end
            m_phase = 0;
          end
        end
      end
    end
  end

  // compare every cycle, away from the active edge
  always @(negedge clk) begin
    chk(out_sel === m_out, "R2/R4", "out_sel", out_sel, m_out);
    chk(src_sel === m_src, "R3", "src_sel", src_sel, m_src);
    chk(busy === (m_phase != 0), "R2/R3/R5", "busy", busy, m_phase != 0);
    chk(pre_ack === m_pack, "R3", "pre_ack", pre_ack, m_pack);
    chk(post_ack === m_qack, "R5", "post_ack", post_ack, m_qack);
    chk(err_busy === m_eb, "R6", "err_busy", err_busy, m_eb);
    chk(err_order === m_eo, "R7", "err_order", err_order, m_eo);
    chk(!(pre_ack && post_ack), "R9", "acks_together", pre_ack && post_ack, 0);
    chk(!(pre_ack && prev_pack), "R9", "pre_ack_width", 2, 1);
    chk(!(post_ack && prev_qack), "R9", "post_ack_width", 2, 1);
    prev_pack = pre_ack;
    prev_qack = post_ack;
  end

  task automatic pulse(input bit p, input bit q);
    @(negedge clk);
    pre_req <= p; post_req <= q;
    @(negedge clk);
    pre_req <= 0; post_req <= 0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 2000 && busy; i++) @(negedge clk);
  endtask

  task automatic check_reset_state(input string tag);
    chk(out_sel === 0 && src_sel === 0 && busy === 0 && pre_ack === 0 &&
        post_ack === 0 && err_busy === 0 && err_order === 0,
        "R1", tag, {out_sel, src_sel, busy, pre_ack, post_ack, err_busy, err_order}, 0);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    check_reset_state("reset_outputs");
    rst_n <= 1;
    @(negedge clk);
    check_reset_state("after_release");
    repeat (20) @(negedge clk);                // R10: idle ticks, no effect
    chk(busy === 0 && out_sel === 0, "R10", "idle_ticks", busy, 0);

    pulse(0, 1);                               // R7 post before any pre
    chk(busy === 0, "R7", "post_rejected_busy", busy, 0);

    pulse(1, 0);                               // R2 park
    chk(busy === 1 && out_sel === 0, "R2", "parked", busy, 1);
    repeat (30) @(negedge clk);
    pulse(1, 0);                               // R6 collisions
    pulse(0, 1);
    wait_idle();
    chk(src_sel === 1, "R3", "src_on_pll", src_sel, 1);

    pulse(0, 1);                               // R4 restore
    chk(busy === 1 && out_sel === 1, "R4", "restoring", out_sel, 1);
    repeat (50) @(negedge clk);
    pulse(1, 0);                               // R6 during restore
    wait_idle();
    chk(out_sel === 1 && src_sel === 1, "R5", "restored", out_sel, 1);

    pulse(0, 1);                               // R7 second post
    pulse(1, 1);                               // R8 collision while idle
    chk(busy === 1 && out_sel === 0, "R8", "pre_wins", busy, 1);
    wait_idle();

    tick_div = 1;
    pulse(0, 1);
    wait_idle();
    tick_div = 5;
    pulse(1, 0);
    repeat (40) @(negedge clk);
    rst_n <= 0;                                // R1 reset mid-phase
    repeat (3) @(negedge clk);
    check_reset_state("mid_phase_reset");
    rst_n <= 1;
    repeat (10) @(negedge clk);
    done = 1;
  end

  initial begin
    wait (done || cycles > 150000);
    if (!done) begin
      compared++; mismatched++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule